// File: doc/BRIEF.md
# Miss Entry Coherence Controller

This block holds the control state of one outstanding-miss tracking entry in a cache. It keeps two small target queues, a primary queue that is served by the request already sent downstream and a deferred queue that must wait for a later request. It also keeps the coherence flags that decide how later requests and snoops are treated: issued, downstream-waiting, ownership-expected, invalidate-after-fill and downgrade-after-fill.

The surrounding cache sends the entry one command per cycle. The commands are allocate, add a target, mark issued, snoop, fill, promote the deferred queue, pop the primary head, release, and flag that the request is still waiting downstream. Each accepted snoop produces a registered answer one cycle later. The answer says whether the entry claimed the snoop, whether memory must be inhibited and ownership handed over, whether a shared response is due, and whether a copy of the snoop was queued as a target. Data storage and the tag array are not part of this block.

Top module: `miss_entry_ctrl`

## Requirements
- R1: After reset both queue counts are zero, and every coherence flag, the error flag and the snoop answer outputs are low.
- R2: Allocate loads one primary target and empties the deferred queue. That target has source 1 (prefetch) when its command code is 5 (prefetch) and source 0 (core) otherwise, and its pending mark is set. Allocate also records the address and the order, and clears the issued and downstream-waiting flags.
- R3: An added target goes to the deferred queue when the entry is issued and at least one of these holds: the deferred queue is not empty; invalidate-after-fill is set; or the target needs ownership (codes 1, 2, 3, 7) and ownership-expected is clear, downgrade-after-fill is set, or the entry is a forward. Otherwise it goes to the primary queue.
- R4: A target that is deferred while invalidate-after-fill is set has its upgrade command rewritten before it is stored: upgrade (2) becomes read-exclusive (1) and conditional store (3) becomes failed store (7). A target placed in the primary queue gets a pending mark equal to the inverse of the issued flag.
- R5: Mark-issued sets the issued flag and clears both after-fill flags. It sets ownership-expected to (primary queue needs ownership) OR (response not shared AND inhibit asserted).
- R6: A snoop that arrives while the entry is not issued, or that is express while downstream-waiting is set, leaves the flags unchanged and is answered as not claimed. If it needs ownership, the upgrade commands in both queues are rewritten.
- R7: A claimed snoop that needs ownership rewrites the upgrades in the deferred queue only. Once invalidate-after-fill is set, any later snoop is claimed with no other effect.
- R8: If ownership is expected or the snoop invalidates, a copy with source 2 and command 4 is appended to the primary queue and enqueue is signalled. Ownership-expected additionally raises memory-inhibit and ownership-supply. A snoop that needs ownership and is queued in this way sets invalidate-after-fill.
- R9: A claimed snoop that does not need ownership and finds invalidate-after-fill clear sets downgrade-after-fill and raises the shared response.
- R10: Promote is acted on only when the primary queue is empty; a promote with a non-empty primary queue sets the error flag and changes nothing else. A promote swaps the queues, clears the new deferred queue's flags, takes the order from the new head, and sets the ready time to the larger of the current time and the head's ready time.
- R11: A fill merges the deferred queue onto the tail of the primary queue, with pending marks cleared, when all of these hold: the fill is not shared, neither after-fill flag is set, and the deferred queue needs ownership.
- R12: Release with a non-empty primary queue sets a sticky error flag, which is cleared only by reset. A release with an empty primary queue clears the issued flag and the coherence flags.
- R13: When several command strobes are high in one cycle, only one is acted on, in the order allocate, fill, snoop, add, mark-issued, promote, pop, release, downstream-waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_i | input | 1 | Allocate the entry |
| fill_i | input | 1 | Fill response arrived |
| snoop_i | input | 1 | Snoop presented |
| add_i | input | 1 | Add a target |
| svc_i | input | 1 | Mark the request issued |
| promote_i | input | 1 | Promote the deferred queue |
| pop_i | input | 1 | Remove the primary head |
| dealloc_i | input | 1 | Release the entry |
| dpend_set_i | input | 1 | Request still waiting downstream |
| addr_i | input | AW | Address recorded on allocate |
| fwd_i | input | 1 | Entry is a forward (allocate) |
| req_cmd_i | input | 3 | Target command code |
| req_order_i | input | OW | Target or snoop order |
| req_ready_i | input | TW | Target ready time |
| now_i | input | TW | Current time |
| rsp_shared_i | input | 1 | Issued response shared bit |
| rsp_inhibit_i | input | 1 | Issued response inhibit bit |
| snp_excl_i | input | 1 | Snoop needs ownership |
| snp_inval_i | input | 1 | Snoop invalidates |
| snp_express_i | input | 1 | Snoop is express |
| fill_shared_i | input | 1 | Fill shared bit |
| snp_vld_o | output | 1 | Snoop answer valid |
| snp_handled_o | output | 1 | Snoop claimed |
| snp_inhibit_o | output | 1 | Memory inhibit |
| snp_supply_o | output | 1 | Ownership supplied |
| snp_shared_o | output | 1 | Shared response |
| snp_enq_o | output | 1 | Snoop copy queued |
| in_service_o | output | 1 | Issued flag |
| dpend_o | output | 1 | Downstream-waiting flag |
| pend_dirty_o | output | 1 | Ownership-expected flag |
| post_inv_o | output | 1 | Invalidate-after-fill flag |
| post_dgr_o | output | 1 | Downgrade-after-fill flag |
| err_o | output | 1 | Sticky protocol error |
| prim_cnt_o | output | CW | Primary queue count |
| defer_cnt_o | output | CW | Deferred queue count |
| head_cmd_o | output | 3 | Primary head command |
| head_src_o | output | 2 | Primary head source |
| head_mark_o | output | 1 | Primary head pending mark |
| addr_o | output | AW | Recorded address |
| order_o | output | OW | Entry order |
| ready_o | output | TW | Entry ready time |

## Verification
The hardest state to reach is a deferred upgrade that was rewritten because of an earlier invalidating snoop, because it only becomes visible after the primary queue has drained and been promoted. To get there, the bench issues the entry with ownership expected, queues an upgrade into the primary queue, and sends an invalidating snoop so that a copy is queued and invalidate-after-fill is set. It then adds a second upgrade, pops the three primary targets one at a time while checking each head, and promotes. The exclusive-grant merge is reached in a similar way: a shared fill and a fill after a downgrade snoop must leave the deferred queue in place, and only an unshared fill may move it.

// File: rtl/miss_entry_pkg.sv
package miss_entry_pkg;
  localparam logic [2:0] CMD_READ     = 3'd0;
  localparam logic [2:0] CMD_READ_EX  = 3'd1;
  localparam logic [2:0] CMD_UPGRADE  = 3'd2;
  localparam logic [2:0] CMD_STCOND   = 3'd3;
  localparam logic [2:0] CMD_SNOOPCPY = 3'd4;
  localparam logic [2:0] CMD_PREFETCH = 3'd5;
  localparam logic [2:0] CMD_SCFAIL   = 3'd7;

  localparam logic [1:0] SRC_CPU   = 2'd0;
  localparam logic [1:0] SRC_PREF  = 2'd1;
  localparam logic [1:0] SRC_SNOOP = 2'd2;

  function automatic logic needs_own(input logic [2:0] c);
    return (c == CMD_READ_EX) || (c == CMD_UPGRADE) ||
           (c == CMD_STCOND) || (c == CMD_SCFAIL);
  endfunction

  function automatic logic [2:0] demote_upg(input logic [2:0] c);
    if (c == CMD_UPGRADE) return CMD_READ_EX;
    if (c == CMD_STCOND)  return CMD_SCFAIL;
    return c;
  endfunction
endpackage

// File: rtl/miss_cmd_arb.sv
module miss_cmd_arb #(
  parameter int N = 9
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  logic seen;
  always_comb begin
    seen = 1'b0;
    for (int i = 0; i < N; i++) begin
      gnt[i] = req[i] && !seen;
      seen   = seen || req[i];
    end
  end
endmodule

// File: rtl/miss_route_dec.sv
module miss_route_dec
  import miss_entry_pkg::*;
(
  input  logic       in_svc,
  input  logic       dfr_nonempty,
  input  logic       post_inv,
  input  logic       post_dgr,
  input  logic       pend_dirty,
  input  logic       is_fwd,
  input  logic [2:0] cmd_in,
  output logic       to_defer,
  output logic       mark,
  output logic [2:0] cmd_out
);
  always_comb begin
    to_defer = in_svc && (dfr_nonempty || post_inv ||
               (needs_own(cmd_in) && (!pend_dirty || post_dgr || is_fwd)));
    cmd_out  = (to_defer && post_inv) ? demote_upg(cmd_in) : cmd_in;
    mark     = to_defer ? 1'b1 : !in_svc;
  end
endmodule

// File: rtl/miss_snoop_dec.sv
module miss_snoop_dec (
  input  logic in_svc,
  input  logic dpend,
  input  logic express,
  input  logic excl,
  input  logic inval,
  input  logic pend_dirty,
  input  logic post_inv,
  input  logic prim_own,
  output logic handled,
  output logic rw_prim,
  output logic rw_dfr,
  output logic enq,
  output logic enq_mark,
  output logic inhibit,
  output logic set_pinv,
  output logic set_pdgr
);
  logic bypass, act;
  always_comb begin
    bypass   = !in_svc || (express && dpend);
    act      = !bypass && !post_inv;
    handled  = !bypass;
    rw_prim  = bypass && excl;
    rw_dfr   = excl;
    enq      = act && (pend_dirty || inval);
    enq_mark = dpend && prim_own;
    inhibit  = enq && pend_dirty;
    set_pinv = enq && excl;
    set_pdgr = act && !excl;
  end
endmodule

// File: rtl/miss_entry_ctrl.sv
module miss_entry_ctrl
  import miss_entry_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int AW    = 16,
  parameter int OW    = 8,
  parameter int TW    = 16,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          alloc_i,
  input  logic          fill_i,
  input  logic          snoop_i,
  input  logic          add_i,
  input  logic          svc_i,
  input  logic          promote_i,
  input  logic          pop_i,
  input  logic          dealloc_i,
  input  logic          dpend_set_i,
  input  logic [AW-1:0] addr_i,
  input  logic          fwd_i,
  input  logic [2:0]    req_cmd_i,
  input  logic [OW-1:0] req_order_i,
  input  logic [TW-1:0] req_ready_i,
  input  logic [TW-1:0] now_i,
  input  logic          rsp_shared_i,
  input  logic          rsp_inhibit_i,
  input  logic          snp_excl_i,
  input  logic          snp_inval_i,
  input  logic          snp_express_i,
  input  logic          fill_shared_i,
  output logic          snp_vld_o,
  output logic          snp_handled_o,
  output logic          snp_inhibit_o,
  output logic          snp_supply_o,
  output logic          snp_shared_o,
  output logic          snp_enq_o,
  output logic          in_service_o,
  output logic          dpend_o,
  output logic          pend_dirty_o,
  output logic          post_inv_o,
  output logic          post_dgr_o,
  output logic          err_o,
  output logic [CW-1:0] prim_cnt_o,
  output logic [CW-1:0] defer_cnt_o,
  output logic [2:0]    head_cmd_o,
  output logic [1:0]    head_src_o,
  output logic          head_mark_o,
  output logic [AW-1:0] addr_o,
  output logic [OW-1:0] order_o,
  output logic [TW-1:0] ready_o
);
  localparam int NCMD = 9;
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  // two physical banks; sel_q names the one acting as primary queue
  logic [2:0]    cmd_q  [2][DEPTH];
  logic [1:0]    src_q  [2][DEPTH];
  logic          mark_q [2][DEPTH];
  logic [OW-1:0] ord_q  [2][DEPTH];
  logic [TW-1:0] rdy_q  [2][DEPTH];
  logic [CW-1:0] cnt_q  [2];
  logic          own_q  [2];
  logic          sel_q;

  logic in_svc_q, dpend_q, pdirty_q, pinv_q, pdgr_q, fwd_q, err_q;
  logic snp_vld_q, snp_hit_q, snp_inh_q, snp_shr_q, snp_enq_q;
  logic [AW-1:0] addr_q;
  logic [OW-1:0] order_q;
  logic [TW-1:0] ready_q;

  logic prim, dfr;
  assign prim = sel_q;
  assign dfr  = ~sel_q;

  logic [NCMD-1:0] req, gnt;
  assign req = {dpend_set_i, dealloc_i, pop_i, promote_i, svc_i,
                add_i, snoop_i, fill_i, alloc_i};

  miss_cmd_arb #(.N(NCMD)) u_arb (.req(req), .gnt(gnt));

  logic       rt_defer, rt_mark;
  logic [2:0] rt_cmd;
  miss_route_dec u_route (
    .in_svc(in_svc_q), .dfr_nonempty(cnt_q[dfr] != '0), .post_inv(pinv_q),
    .post_dgr(pdgr_q), .pend_dirty(pdirty_q), .is_fwd(fwd_q),
    .cmd_in(req_cmd_i), .to_defer(rt_defer), .mark(rt_mark), .cmd_out(rt_cmd)
  );

  logic sd_hit, sd_rwp, sd_rwd, sd_enq, sd_emark, sd_inh, sd_pinv, sd_pdgr;
  miss_snoop_dec u_snoop (
    .in_svc(in_svc_q), .dpend(dpend_q), .express(snp_express_i),
    .excl(snp_excl_i), .inval(snp_inval_i), .pend_dirty(pdirty_q),
    .post_inv(pinv_q), .prim_own(own_q[prim]), .handled(sd_hit),
    .rw_prim(sd_rwp), .rw_dfr(sd_rwd), .enq(sd_enq), .enq_mark(sd_emark),
    .inhibit(sd_inh), .set_pinv(sd_pinv), .set_pdgr(sd_pdgr)
  );

  logic          add_bank;
  logic [CW:0]   merge_sum;
  logic          merge_ok;
  assign add_bank  = rt_defer ? dfr : prim;
  assign merge_sum = {1'b0, cnt_q[prim]} + {1'b0, cnt_q[dfr]};
  assign merge_ok  = !fill_shared_i && !pinv_q && !pdgr_q && own_q[dfr];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int b = 0; b < 2; b++) begin
        cnt_q[b] <= '0;
        own_q[b] <= 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
          cmd_q[b][i] <= '0; src_q[b][i] <= '0; mark_q[b][i] <= 1'b0;
          ord_q[b][i] <= '0; rdy_q[b][i] <= '0;
        end
      end
      sel_q <= 1'b0;
      in_svc_q <= 1'b0; dpend_q <= 1'b0; pdirty_q <= 1'b0;
      pinv_q <= 1'b0; pdgr_q <= 1'b0; fwd_q <= 1'b0; err_q <= 1'b0;
      snp_vld_q <= 1'b0; snp_hit_q <= 1'b0; snp_inh_q <= 1'b0;
      snp_shr_q <= 1'b0; snp_enq_q <= 1'b0;
      addr_q <= '0; order_q <= '0; ready_q <= '0;
    end else begin
      snp_vld_q <= 1'b0; snp_hit_q <= 1'b0; snp_inh_q <= 1'b0;
      snp_shr_q <= 1'b0; snp_enq_q <= 1'b0;
      if (gnt[0]) begin
        cnt_q[prim] <= CW'(1);
        cnt_q[dfr]  <= '0;
        own_q[prim] <= needs_own(req_cmd_i);
        own_q[dfr]  <= 1'b0;
        cmd_q[prim][0]  <= req_cmd_i;
        src_q[prim][0]  <= (req_cmd_i == CMD_PREFETCH) ? SRC_PREF : SRC_CPU;
        mark_q[prim][0] <= 1'b1;
        ord_q[prim][0]  <= req_order_i;
        rdy_q[prim][0]  <= req_ready_i;
        in_svc_q <= 1'b0; dpend_q <= 1'b0; pdirty_q <= 1'b0;
        pinv_q <= 1'b0; pdgr_q <= 1'b0; fwd_q <= fwd_i;
        addr_q <= addr_i; order_q <= req_order_i; ready_q <= req_ready_i;
      end else if (gnt[1]) begin
        if (merge_ok) begin
          own_q[prim] <= 1'b1;
          own_q[dfr]  <= 1'b0;
          for (int i = 0; i < DEPTH; i++) begin
            if ((CW'(i) < cnt_q[dfr]) && (int'(cnt_q[prim]) + i < DEPTH)) begin
              cmd_q[prim][IW'(int'(cnt_q[prim]) + i)]  <= cmd_q[dfr][i];
              src_q[prim][IW'(int'(cnt_q[prim]) + i)]  <= src_q[dfr][i];
              mark_q[prim][IW'(int'(cnt_q[prim]) + i)] <= 1'b0;
              ord_q[prim][IW'(int'(cnt_q[prim]) + i)]  <= ord_q[dfr][i];
              rdy_q[prim][IW'(int'(cnt_q[prim]) + i)]  <= rdy_q[dfr][i];
            end
          end
          cnt_q[dfr] <= '0;
          if (merge_sum > (CW+1)'(DEPTH)) begin
            cnt_q[prim] <= FULL;
            err_q       <= 1'b1;
          end else begin
            cnt_q[prim] <= merge_sum[CW-1:0];
          end
        end
      end else if (gnt[2]) begin
        snp_vld_q <= 1'b1;
        snp_hit_q <= sd_hit;
        snp_inh_q <= sd_inh;
        snp_shr_q <= sd_pdgr;
        for (int i = 0; i < DEPTH; i++) begin
          if (sd_rwp && CW'(i) < cnt_q[prim]) cmd_q[prim][i] <= demote_upg(cmd_q[prim][i]);
          if (sd_rwd && CW'(i) < cnt_q[dfr])  cmd_q[dfr][i]  <= demote_upg(cmd_q[dfr][i]);
        end
        if (sd_enq) begin
          if (cnt_q[prim] == FULL) begin
            err_q <= 1'b1;
          end else begin
            cmd_q[prim][IW'(cnt_q[prim])]  <= CMD_SNOOPCPY;
            src_q[prim][IW'(cnt_q[prim])]  <= SRC_SNOOP;
            mark_q[prim][IW'(cnt_q[prim])] <= sd_emark;
            ord_q[prim][IW'(cnt_q[prim])]  <= req_order_i;
            rdy_q[prim][IW'(cnt_q[prim])]  <= now_i;
            cnt_q[prim] <= cnt_q[prim] + 1'b1;
            snp_enq_q   <= 1'b1;
          end
        end
        if (sd_pinv) pinv_q <= 1'b1;
        if (sd_pdgr) pdgr_q <= 1'b1;
      end else if (gnt[3]) begin
        if (cnt_q[add_bank] == FULL) begin
          err_q <= 1'b1;
        end else begin
          cmd_q[add_bank][IW'(cnt_q[add_bank])]  <= rt_cmd;
          src_q[add_bank][IW'(cnt_q[add_bank])]  <= SRC_CPU;
          mark_q[add_bank][IW'(cnt_q[add_bank])] <= rt_mark;
          ord_q[add_bank][IW'(cnt_q[add_bank])]  <= req_order_i;
          rdy_q[add_bank][IW'(cnt_q[add_bank])]  <= req_ready_i;
          cnt_q[add_bank] <= cnt_q[add_bank] + 1'b1;
          if (needs_own(rt_cmd)) own_q[add_bank] <= 1'b1;
        end
      end else if (gnt[4]) begin
        in_svc_q <= 1'b1;
        pdirty_q <= own_q[prim] || (!rsp_shared_i && rsp_inhibit_i);
        pinv_q   <= 1'b0;
        pdgr_q   <= 1'b0;
      end else if (gnt[5]) begin
        if (cnt_q[prim] != '0) begin
          err_q <= 1'b1;
        end else if (cnt_q[dfr] != '0) begin
          sel_q       <= ~sel_q;
          own_q[prim] <= 1'b0;
          order_q     <= ord_q[dfr][0];
          ready_q     <= (rdy_q[dfr][0] > now_i) ? rdy_q[dfr][0] : now_i;
        end
      end else if (gnt[6]) begin
        if (cnt_q[prim] != '0) begin
          for (int i = 0; i < DEPTH - 1; i++) begin
            cmd_q[prim][i]  <= cmd_q[prim][i+1];
            src_q[prim][i]  <= src_q[prim][i+1];
            mark_q[prim][i] <= mark_q[prim][i+1];
            ord_q[prim][i]  <= ord_q[prim][i+1];
            rdy_q[prim][i]  <= rdy_q[prim][i+1];
          end
          cnt_q[prim] <= cnt_q[prim] - 1'b1;
        end
      end else if (gnt[7]) begin
        if (cnt_q[prim] != '0) begin
          err_q <= 1'b1;
        end else begin
          in_svc_q <= 1'b0; dpend_q <= 1'b0; pdirty_q <= 1'b0;
          pinv_q <= 1'b0; pdgr_q <= 1'b0; own_q[prim] <= 1'b0;
        end
      end else if (gnt[8]) begin
        dpend_q <= 1'b1;
      end
    end
  end

  assign snp_vld_o     = snp_vld_q;
  assign snp_handled_o = snp_hit_q;
  assign snp_inhibit_o = snp_inh_q;
  assign snp_supply_o  = snp_inh_q;
  assign snp_shared_o  = snp_shr_q;
  assign snp_enq_o     = snp_enq_q;
  assign in_service_o  = in_svc_q;
  assign dpend_o       = dpend_q;
  assign pend_dirty_o  = pdirty_q;
  assign post_inv_o    = pinv_q;
  assign post_dgr_o    = pdgr_q;
  assign err_o         = err_q;
  assign prim_cnt_o    = cnt_q[prim];
  assign defer_cnt_o   = cnt_q[dfr];
  assign head_cmd_o    = cmd_q[prim][0];
  assign head_src_o    = src_q[prim][0];
  assign head_mark_o   = mark_q[prim][0];
  assign addr_o        = addr_q;
  assign order_o       = order_q;
  assign ready_o       = ready_q;

  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (prim_cnt_o <= FULL) && (defer_cnt_o <= FULL));
  // R5
  svc_flags_chk: assert property (@(posedge clk) disable iff (rst)
    gnt[4] |=> in_service_o && !post_inv_o && !post_dgr_o);
  // R6
  snoop_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (gnt[2] && !in_service_o) |=> snp_vld_o && !snp_handled_o && !snp_enq_o);
  // R8
  inhibit_chk: assert property (@(posedge clk) disable iff (rst)
    snp_inhibit_o |-> snp_enq_o && snp_handled_o);
  // R9
  snoop_share_chk: assert property (@(posedge clk) disable iff (rst)
    (gnt[2] && in_service_o && !snp_excl_i && !post_inv_o &&
     !(snp_express_i && dpend_o)) |=> post_dgr_o && snp_shared_o);
  // R10
  promote_swap_chk: assert property (@(posedge clk) disable iff (rst)
    (gnt[5] && prim_cnt_o == '0 && defer_cnt_o != '0)
      |=> prim_cnt_o == $past(defer_cnt_o) && defer_cnt_o == '0);
  // R12
  dealloc_err_chk: assert property (@(posedge clk) disable iff (rst)
    (gnt[7] && prim_cnt_o != '0) |=> err_o);
  // R12
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    err_o |=> err_o);
endmodule

// File: tb/tb_miss_entry_ctrl.sv
module tb_miss_entry_ctrl;
  localparam int DEPTH = 4;
  localparam int AW = 16, OW = 8, TW = 16;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst = 1'b1;
  logic alloc_i, fill_i, snoop_i, add_i, svc_i, promote_i, pop_i, dealloc_i, dpend_set_i;
  logic [AW-1:0] addr_i;
  logic fwd_i;
  logic [2:0] req_cmd_i;
  logic [OW-1:0] req_order_i;
  logic [TW-1:0] req_ready_i, now_i;
  logic rsp_shared_i, rsp_inhibit_i, snp_excl_i, snp_inval_i, snp_express_i, fill_shared_i;
  logic snp_vld_o, snp_handled_o, snp_inhibit_o, snp_supply_o, snp_shared_o, snp_enq_o;
  logic in_service_o, dpend_o, pend_dirty_o, post_inv_o, post_dgr_o, err_o;
  logic [CW-1:0] prim_cnt_o, defer_cnt_o;
  logic [2:0] head_cmd_o;
  logic [1:0] head_src_o;
  logic head_mark_o;
  logic [AW-1:0] addr_o;
  logic [OW-1:0] order_o;
  logic [TW-1:0] ready_o;

  miss_entry_ctrl #(.DEPTH(DEPTH), .AW(AW), .OW(OW), .TW(TW)) dut (.*);

  always #10 clk = ~clk;

  int nchk = 0, nfail = 0;
  bit done = 0;

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clr();
    alloc_i = 0; fill_i = 0; snoop_i = 0; add_i = 0; svc_i = 0;
    promote_i = 0; pop_i = 0; dealloc_i = 0; dpend_set_i = 0;
  endtask

  task automatic tick();
    @(posedge clk); #2; clr();
  endtask

  task automatic do_reset();
    clr(); rst = 1; addr_i = 0; fwd_i = 0; req_cmd_i = 0; req_order_i = 0;
    req_ready_i = 0; now_i = 0; rsp_shared_i = 0; rsp_inhibit_i = 0;
    snp_excl_i = 0; snp_inval_i = 0; snp_express_i = 0; fill_shared_i = 0;
    repeat (3) @(posedge clk);
    #2; rst = 0;
  endtask

  task automatic do_alloc(input logic [2:0] c, input int ord, input int rdy);
    alloc_i = 1; req_cmd_i = c; req_order_i = OW'(ord); req_ready_i = TW'(rdy); tick();
  endtask
  task automatic do_add(input logic [2:0] c, input int ord, input int rdy);
    add_i = 1; req_cmd_i = c; req_order_i = OW'(ord); req_ready_i = TW'(rdy); tick();
  endtask
  task automatic do_svc(input logic sh, input logic inh);
    svc_i = 1; rsp_shared_i = sh; rsp_inhibit_i = inh; tick();
  endtask
  task automatic do_snoop(input logic ex, input logic inv, input logic xp);
    snoop_i = 1; snp_excl_i = ex; snp_inval_i = inv; snp_express_i = xp; tick();
  endtask
  task automatic do_fill(input logic sh);
    fill_i = 1; fill_shared_i = sh; tick();
  endtask
  task automatic do_pop();     pop_i = 1; tick();     endtask
  task automatic do_promote(); promote_i = 1; tick(); endtask
  task automatic do_dealloc(); dealloc_i = 1; tick(); endtask

  // {cmd[3], svc, rsp_shared, rsp_inhibit, s_excl, s_inval, s_express,
  //  exp handled, inhibit, shared, enq, post_inv, post_dgr}
  localparam logic [14:0] VEC [8] = '{
    15'b000_000_110_000000,
    15'b000_100_000_101001,
    15'b001_100_110_110110,
    15'b000_101_000_111101,
    15'b000_111_110_100110,
    15'b000_100_100_100000,
    15'b001_100_001_111101,
    15'b101_000_000_000000
  };

  initial begin
    #(20 * 200000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: got 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 prim", prim_cnt_o, 0); chk("R1 defer", defer_cnt_o, 0);
    chk("R1 svc", in_service_o, 0); chk("R1 err", err_o, 0);
    chk("R1 flags", {pend_dirty_o, post_inv_o, post_dgr_o, dpend_o, snp_vld_o}, 0);

    // snoop decision table (R6 R8 R9)
    for (int v = 0; v < 8; v++) begin
      do_reset();
      do_alloc(VEC[v][14:12], 1, 0);
      if (VEC[v][11]) do_svc(VEC[v][10], VEC[v][9]);
      do_snoop(VEC[v][8], VEC[v][7], VEC[v][6]);
      chk("R6 handled", snp_handled_o, VEC[v][5]);
      chk("R8 inhibit", snp_inhibit_o, VEC[v][4]);
      chk("R8 supply", snp_supply_o, VEC[v][4]);
      chk("R9 shared", snp_shared_o, VEC[v][3]);
      chk("R8 enq", snp_enq_o, VEC[v][2]);
      chk("R8 post_inv", post_inv_o, VEC[v][1]);
      chk("R9 post_dgr", post_dgr_o, VEC[v][0]);
      chk("R8 prim count", prim_cnt_o, 1 + VEC[v][2]);
    end

    // R2 allocate of a prefetch
    do_reset();
    addr_i = 16'hABC;
    do_alloc(3'd5, 7, 3);
    chk("R2 prim", prim_cnt_o, 1); chk("R2 src", head_src_o, 1);
    chk("R2 mark", head_mark_o, 1); chk("R2 order", order_o, 7);
    chk("R2 addr", addr_o, 16'hABC); chk("R2 svc", in_service_o, 0);
    // R3 not issued -> primary, R4 mark = !issued
    do_add(3'd1, 8, 0);
    chk("R3 prim", prim_cnt_o, 2); chk("R3 defer", defer_cnt_o, 0);
    do_pop();
    chk("R4 mark", head_mark_o, 1); chk("R2 src cpu", head_src_o, 0);

    // R3 routing to deferred
    do_reset();
    do_alloc(3'd0, 1, 0); do_svc(0, 0);
    chk("R5 pdirty", pend_dirty_o, 0);
    do_add(3'd1, 4, 5);
    chk("R3 own defer", defer_cnt_o, 1);
    do_add(3'd0, 6, 0);
    chk("R3 nonempty defer", defer_cnt_o, 2);
    chk("R3 prim", prim_cnt_o, 1);
    do_pop(); now_i = 100; do_promote();
    chk("R10 order", order_o, 4); chk("R10 ready now", ready_o, 100);
    chk("R10 prim", prim_cnt_o, 2); chk("R10 defer", defer_cnt_o, 0);

    // R4/R7 rewrite through invalidate-after-fill
    do_reset();
    do_alloc(3'd1, 1, 0); do_svc(0, 0);
    chk("R5 pdirty own", pend_dirty_o, 1);
    do_add(3'd2, 2, 0);
    chk("R3 own ok prim", prim_cnt_o, 2);
    do_snoop(1, 1, 0);
    chk("R8 enq", snp_enq_o, 1); chk("R8 pinv", post_inv_o, 1);
    do_add(3'd2, 9, 500);
    chk("R3 pinv defer", defer_cnt_o, 1);
    do_snoop(0, 0, 0);
    chk("R7 handled", snp_handled_o, 1); chk("R7 no enq", snp_enq_o, 0);
    chk("R7 no dgr", post_dgr_o, 0); chk("R7 no shared", snp_shared_o, 0);
    chk("R7 prim", prim_cnt_o, 3);
    do_pop();
    chk("R7 prim upg kept", head_cmd_o, 2); chk("R4 mark issued", head_mark_o, 0);
    do_pop();
    chk("R8 copy src", head_src_o, 2); chk("R8 copy cmd", head_cmd_o, 4);
    do_pop();
    now_i = 100; do_promote();
    chk("R4 rewritten", head_cmd_o, 1); chk("R10 order", order_o, 9);
    chk("R10 ready head", ready_o, 500);

    // R6 express snoop while downstream-waiting
    do_reset();
    do_alloc(3'd2, 1, 0); do_svc(0, 0);
    dpend_set_i = 1; tick();
    do_snoop(1, 1, 1);
    chk("R6 express", snp_handled_o, 0); chk("R6 rewrite prim", head_cmd_o, 1);
    chk("R6 no pinv", post_inv_o, 0);

    // R11 merge on fill
    do_reset();
    do_alloc(3'd0, 1, 0); do_svc(0, 0); do_add(3'd1, 4, 0);
    do_fill(1);
    chk("R11 shared no merge", defer_cnt_o, 1);
    do_fill(0);
    chk("R11 merged prim", prim_cnt_o, 2); chk("R11 merged defer", defer_cnt_o, 0);
    do_pop();
    chk("R11 cmd", head_cmd_o, 1); chk("R11 mark cleared", head_mark_o, 0);
    do_reset();
    do_alloc(3'd0, 1, 0); do_svc(0, 0); do_add(3'd1, 4, 0);
    do_snoop(0, 0, 0); do_fill(0);
    chk("R11 dgr no merge", defer_cnt_o, 1);

    // R10 illegal promote
    do_promote();
    chk("R10 illegal err", err_o, 1); chk("R10 illegal defer", defer_cnt_o, 1);

    // R12 release
    do_reset();
    do_alloc(3'd0, 1, 0); do_svc(0, 0); do_dealloc();
    chk("R12 err", err_o, 1); chk("R12 svc kept", in_service_o, 1);
    do_alloc(3'd0, 2, 0);
    chk("R12 sticky", err_o, 1);
    do_svc(0, 0); do_pop(); do_dealloc();
    chk("R12 released", in_service_o, 0);

    // R13 priority
    do_reset();
    alloc_i = 1; add_i = 1; req_cmd_i = 3'd0; tick();
    chk("R13 alloc over add", prim_cnt_o, 1);
    do_svc(0, 0);
    snoop_i = 1; add_i = 1; req_cmd_i = 3'd1; snp_excl_i = 0; snp_inval_i = 0; snp_express_i = 0; tick();
    chk("R13 snoop taken", snp_vld_o, 1); chk("R13 add dropped", defer_cnt_o, 0);
    chk("R13 add dropped prim", prim_cnt_o, 1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule